// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker

This block watches a stream of 10-bit video words and picks out ancillary data packets by their three-word header. For each packet it adds up the data identifier, the secondary identifier (or block number), the data count and every user data word. It then compares that sum with the checksum word that closes the packet. Each packet produces a one-cycle done pulse. A mismatch on a packet that the type filter selects sets a sticky error flag, which stays set until the host clears it.

The host programs a small table of data identifier values with an enable bit per entry. When no entry is enabled, every packet is verified. When at least one entry is enabled, only packets whose identifier matches an enabled entry can raise the flag. Words that arrive with the valid strobe low are ignored. A new header that appears in the middle of a packet throws away the partial sum and starts a new packet.

Top module: `anc_csum_check`

## Requirements
- R1: A packet starts when three consecutive valid words are 000h, 3FFh, 3FFh. The next three valid words are taken as the data identifier, the secondary identifier and the data count.
- R2: Bits 7:0 of the data count word give the number of user data words. The checksum word is the valid word that follows the last user data word, or the one right after the data count word when the count is zero.
- R3: The expected checksum is the sum, modulo 512, of bits 8:0 of the identifier, secondary identifier, data count and user data words. A received checksum matches only when its bits 8:0 equal that sum and its bit 9 is the inverse of its bit 8.
- R4: `pktDone` is high for exactly one cycle, in the cycle after the checksum word is accepted. This happens for every packet, whether or not the filter selects it.
- R5: A mismatch on a selected packet sets `errFlag` in the same cycle as `pktDone`. The flag then stays set.
- R6: `errClear` clears `errFlag` in the next cycle. If a mismatch sets the flag in the same cycle, the set wins.
- R7: When `typeEn` is all zero, every packet is verified, whatever its identifier.
- R8: When `typeEn` is nonzero, a packet is verified only if bits 7:0 of its identifier word equal a table entry `typeIds[i*8 +: 8]` whose `typeEn[i]` is 1. A mismatch on any other packet leaves `errFlag` unchanged.
- R9: A valid header seen inside an unfinished packet discards that packet. The discarded packet gives no `pktDone` and the new packet is checked normally.
- R10: A word with `wordValid` low changes nothing, including header detection and word counting.
- R11: While reset is active, and right after it, `errFlag` and `pktDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordIn | input | 10 | Video word |
| wordValid | input | 1 | Qualifies wordIn |
| typeIds | input | NUM_IDS*8 (32) | Table of identifier values, entry i in bits i*8+7 : i*8 |
| typeEn | input | NUM_IDS (4) | Enable bit per table entry; all zero selects every packet |
| errClear | input | 1 | Clears the sticky error flag |
| errFlag | output | 1 | Sticky checksum mismatch flag |
| pktDone | output | 1 | One-cycle pulse per completed packet |

## Verification
Every result is registered once. `pktDone` and any new `errFlag` value show up in the cycle after the clock edge that accepts the checksum word. A clear shows up in the cycle after the edge that samples `errClear`. The bench drives each word on the falling edge and checks the outputs on the falling edge after the capturing rising edge, so each check sees exactly one register stage. A running count of `pktDone` pulses, also sampled on falling edges, shows whether a discarded packet produced a pulse.

// File: rtl/anc_csum_pkg.sv
package anc_csum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DID, ST_SDID, ST_DC, ST_UDW, ST_CS
  } ancState_t;

  typedef struct packed {
    logic loadSum;
    logic addSum;
    logic latchId;
    logic checkNow;
  } ancStrobe_t;
endpackage

// File: rtl/anc_csum_ctrl.sv
module anc_csum_ctrl
  import anc_csum_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  output ancStrobe_t        strobes
);
  localparam logic [WORD_W-1:0] ALL_ONES = {WORD_W{1'b1}};

  logic [WORD_W-1:0] prevOne, prevTwo;
  logic              hdrSeen;
  ancState_t         state, stateNext;
  logic [CNT_W-1:0]  remain, remainNext;

  assign hdrSeen = wordValid && (prevTwo == '0) && (prevOne == ALL_ONES)
                   && (wordIn == ALL_ONES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOne <= ALL_ONES;
      prevTwo <= ALL_ONES;
      state   <= ST_IDLE;
      remain  <= '0;
    end else begin
      if (wordValid) begin
        prevTwo <= prevOne;
        prevOne <= wordIn;
      end
      state  <= stateNext;
      remain <= remainNext;
    end
  end

  always_comb begin
    stateNext  = state;
    remainNext = remain;
    strobes    = '0;
    if (wordValid) begin
      if (hdrSeen) begin
        stateNext = ST_DID;
      end else begin
        unique case (state)
          ST_DID: begin
            strobes.loadSum = 1'b1;
            strobes.latchId = 1'b1;
            stateNext = ST_SDID;
          end
          ST_SDID: begin
            strobes.addSum = 1'b1;
            stateNext = ST_DC;
          end
          ST_DC: begin
            strobes.addSum = 1'b1;
            remainNext = wordIn[CNT_W-1:0];
            stateNext = (wordIn[CNT_W-1:0] == '0) ? ST_CS : ST_UDW;
          end
          ST_UDW: begin
            strobes.addSum = 1'b1;
            remainNext = remain - 1'b1;
            if (remain == CNT_W'(1)) stateNext = ST_CS;
          end
          ST_CS: begin
            strobes.checkNow = 1'b1;
            stateNext = ST_IDLE;
          end
          default: stateNext = ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/anc_csum_dp.sv
module anc_csum_dp
  import anc_csum_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int ID_W    = 8,
  parameter int NUM_IDS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WORD_W-1:0]       wordIn,
  input  ancStrobe_t              strobes,
  input  logic [NUM_IDS*ID_W-1:0] typeIds,
  input  logic [NUM_IDS-1:0]      typeEn,
  input  logic                    errClear,
  output logic                    errFlag,
  output logic                    pktDone
);
  localparam int SUM_W = WORD_W - 1;

  logic [SUM_W-1:0]  sumAcc;
  logic [ID_W-1:0]   idHeld;
  logic [NUM_IDS-1:0] idHits;
  logic              selected, mismatch;
  logic [WORD_W-1:0] expectWord;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_match
    assign idHits[i] = typeEn[i] && (typeIds[i*ID_W +: ID_W] == idHeld);
  end

  assign selected   = (typeEn == '0) || (|idHits);
  assign expectWord = {~sumAcc[SUM_W-1], sumAcc};
  assign mismatch   = (wordIn != expectWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumAcc  <= '0;
      idHeld  <= '0;
      errFlag <= 1'b0;
      pktDone <= 1'b0;
    end else begin
      if (strobes.loadSum)     sumAcc <= wordIn[SUM_W-1:0];
      else if (strobes.addSum) sumAcc <= sumAcc + wordIn[SUM_W-1:0];
      if (strobes.latchId) idHeld <= wordIn[ID_W-1:0];
      pktDone <= strobes.checkNow;
      if (strobes.checkNow && mismatch && selected) errFlag <= 1'b1;
      else if (errClear)                            errFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/anc_csum_check.sv
module anc_csum_check
  import anc_csum_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int ID_W    = 8,
  parameter int NUM_IDS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WORD_W-1:0]       wordIn,
  input  logic                    wordValid,
  input  logic [NUM_IDS*ID_W-1:0] typeIds,
  input  logic [NUM_IDS-1:0]      typeEn,
  input  logic                    errClear,
  output logic                    errFlag,
  output logic                    pktDone
);
  ancStrobe_t strobes;

  anc_csum_ctrl #(.WORD_W(WORD_W), .CNT_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .strobes(strobes)
  );

  anc_csum_dp #(.WORD_W(WORD_W), .ID_W(ID_W), .NUM_IDS(NUM_IDS)) u_dp (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .strobes(strobes),
    .typeIds(typeIds), .typeEn(typeEn), .errClear(errClear),
    .errFlag(errFlag), .pktDone(pktDone)
  );
endmodule

// File: rtl/anc_csum_check_sva.sv
module anc_csum_check_sva (
  input logic clk,
  input logic rstN,
  input logic wordValid,
  input logic errClear,
  input logic errFlag,
  input logic pktDone
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);

  assert_done_after_word_R10: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> $past(wordValid));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errFlag) && !$past(errClear)) |-> errFlag);

  assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> pktDone);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errClear) && !pktDone) |-> !errFlag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      assert_reset_R11: assert (!errFlag && !pktDone);
    end
  end
endmodule

bind anc_csum_check anc_csum_check_sva u_sva (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .errClear(errClear),
  .errFlag(errFlag), .pktDone(pktDone)
);

// File: tb/sim_anc_csum_check.sv
`timescale 1ns/1ps
module sim_anc_csum_check;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  wordIn = '0;
  logic        wordValid = 1'b0;
  logic [31:0] typeIds = '0;
  logic [3:0]  typeEn = '0;
  logic        errClear = 1'b0;
  logic        errFlag, pktDone;

  int checks = 0, fails = 0, doneCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  anc_csum_check u0 (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .typeIds(typeIds), .typeEn(typeEn), .errClear(errClear),
    .errFlag(errFlag), .pktDone(pktDone)
  );

  always @(negedge clk) if (rstN && pktDone) doneCount++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic putWord(logic [9:0] w);
    @(negedge clk);
    wordIn = w;
    wordValid = 1'b1;
  endtask

  task automatic idleWord(logic [9:0] junk);
    @(negedge clk);
    wordIn = junk;
    wordValid = 1'b0;
  endtask

  function automatic logic [9:0] udw(int did, int i);
    return 10'(((i * 53 + did * 11) % 1000) + 4);
  endfunction

  function automatic bit selectedId(int did);
    if (typeEn == 0) return 1;
    for (int i = 0; i < 4; i++)
      if (typeEn[i] && typeIds[i*8 +: 8] == 8'(did)) return 1;
    return 0;
  endfunction

  // mode 0 good, 1 flip bit0, 2 wrong bit9; gaps inserts invalid words
  task automatic sendPkt(int did, int n, int mode, bit gaps, bit clrAtCs,
                         output bit expErr);
    logic [8:0] s;
    logic [9:0] cs;
    s = 9'(did) + 9'(did + 3) + 9'(n);
    putWord(10'h000); if (gaps) idleWord(10'h3FF);
    putWord(10'h3FF); if (gaps) idleWord(10'h000);
    putWord(10'h3FF);
    putWord(10'(did)); if (gaps) idleWord(10'h3FF);
    putWord(10'(did + 3));
    putWord(10'(n));
    for (int i = 0; i < n; i++) begin
      putWord(udw(did, i));
      s = s + udw(did, i)[8:0];
      if (gaps) idleWord(10'h000);
    end
    cs = {~s[8], s};
    if (mode == 1) cs = cs ^ 10'h001;
    if (mode == 2) cs = cs ^ 10'h200;
    putWord(cs);
    errClear = clrAtCs;
    expErr = (mode != 0) && selectedId(did);
    @(negedge clk);
    wordValid = 1'b0;
    errClear = 1'b0;
  endtask

  task automatic clearFlag();
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    check("R6 clear", errFlag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    bit e;
    int dids[5] = '{8'h41, 8'h60, 8'h61, 8'h62, 8'h50};
    int cnts[4] = '{0, 1, 2, 7};
    int d0;
    repeat (3) @(negedge clk);
    check("R11 reset flag", errFlag, 0);
    check("R11 reset done", pktDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after reset flag", errFlag, 0);
    check("R11 after reset done", pktDone, 0);

    // R1 R2 R3 R4 R5 R7 R8 sweep
    for (int cfg = 0; cfg < 2; cfg++) begin
      typeIds = {8'h62, 8'h61, 8'h60, 8'h41};
      typeEn  = (cfg == 0) ? 4'b0000 : 4'b0101;
      for (int d = 0; d < 5; d++)
        for (int c = 0; c < 4; c++)
          for (int m = 0; m < 3; m++) begin
            sendPkt(dids[d], cnts[c], m, 0, 0, e);
            check("R4 done pulse (R1 R2)", pktDone, 1);
            check(cfg == 0 ? "R7 R3 R5 flag" : "R8 R3 R5 flag", errFlag, e);
            @(negedge clk);
            check("R4 single cycle", pktDone, 0);
            check("R5 sticky", errFlag, e);
            if (e) clearFlag();
          end
    end

    // R10: invalid words interleaved, including header-like values
    typeEn = 4'b0000;
    sendPkt(8'h45, 5, 0, 1, 0, e);
    check("R10 gaps done", pktDone, 1);
    check("R10 gaps good flag", errFlag, 0);
    sendPkt(8'h45, 5, 1, 1, 0, e);
    check("R10 gaps bad flag", errFlag, 1);
    clearFlag();

    // R6: clear in the same cycle as a mismatch, set wins
    sendPkt(8'h52, 3, 1, 0, 1, e);
    check("R6 set wins", errFlag, 1);
    clearFlag();

    // R9: restart mid-packet
    d0 = doneCount;
    putWord(10'h000); putWord(10'h3FF); putWord(10'h3FF);
    putWord(10'h47); putWord(10'h4A); putWord(10'd5);
    putWord(10'h123); putWord(10'h0AA);
    sendPkt(8'h48, 2, 0, 0, 0, e);
    check("R9 restart done", pktDone, 1);
    check("R9 restart flag", errFlag, 0);
    @(negedge clk);
    check("R9 one done only", doneCount - d0, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule